// File: doc/BRIEF.md
# Selectable Clock Output Divider Mux

This block drives a single clock-out pin from one of several internal clocks. A 3-bit select code picks the source. Four codes send a clock through a fixed divide-by-16. Two codes pass a low-speed clock through with no division. One code gives a reference clock: the system clock divided by a programmable prescale value plus one, then halved. The last code holds the pin low.

Every source clock arrives as a level signal that is sampled in a fast base clock domain. Dividers count the sampled rising edges and toggle a square wave at a constant half period. A new select code or prescale value is held back until the output is low. At that point the divider restarts from zero, so the pin never carries a runt pulse.

Top module: `clk_export_mux`

## Requirements
- R1: While reset is high and in the cycle after it, `ck_out` is 0.
- R2: With select code 3'b000 the output toggles once every (presc+1) sampled rising edges of `sys_ck`. This gives sys/(presc+1)/2.
- R3: With select code 3'b001 the output toggles once every 8 sampled rising edges of `bus_ck`. This gives bus/16.
- R4: With select code 3'b010 the output toggles once every 8 sampled rising edges of `sys_ck`.
- R5: With select code 3'b011 the output toggles once every 8 sampled rising edges of `hse_ck`.
- R6: With select code 3'b100 the output toggles once every 8 sampled rising edges of `hsi_ck`.
- R7: With code 3'b101 the output follows `lse_ck`, and with code 3'b110 it follows `lsi_ck`. In both cases the output lags the input by two base cycles.
- R8: With select code 3'b111 the output stays 0.
- R9: A new select code takes effect only in a cycle whose output is 0. That cycle drives the output 0, and the divider restarts with its count and wave at 0.
- R10: A change of the prescale value is deferred the same way as a select change, and it also restarts the divider.
- R11: Each divided output is 50% duty. The high phase and the low phase each last the same number of source edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast base clock |
| rst | input | 1 | Synchronous active-high reset |
| sys_ck | input | 1 | System clock level, sampled |
| bus_ck | input | 1 | Bus clock level, sampled |
| hse_ck | input | 1 | External high-speed clock level |
| hsi_ck | input | 1 | Internal high-speed clock level |
| lse_ck | input | 1 | External low-speed clock level |
| lsi_ck | input | 1 | Internal low-speed clock level |
| sel | input | 3 | Requested source select code |
| presc | input | PW (8) | Prescale value for the reference code |
| ck_out | output | 1 | Registered clock-out waveform |

## Verification
The hardest case is a reconfiguration that arrives while the output is high. The new code must wait, and it must then take effect on the first low cycle, with the divider restarting from zero. The stimulus changes the select code and the prescale value at arbitrary points: in the middle of high phases, in the middle of low phases, and several times within one period. A behavioural model tracks the pending request and compares the pin on every cycle. A separate measurement counts the high-phase and low-phase lengths of a divided output to confirm the duty cycle.

// File: rtl/clkx_pkg.sv
package clkx_pkg;
  localparam int NSRC = 6;
  localparam int IX_SYS = 0;
  localparam int IX_BUS = 1;
  localparam int IX_HSE = 2;
  localparam int IX_HSI = 3;
  localparam int IX_LSE = 4;
  localparam int IX_LSI = 5;
  localparam logic [2:0] SEL_REF   = 3'b000;
  localparam logic [2:0] SEL_BUS16 = 3'b001;
  localparam logic [2:0] SEL_SYS16 = 3'b010;
  localparam logic [2:0] SEL_HSE16 = 3'b011;
  localparam logic [2:0] SEL_HSI16 = 3'b100;
  localparam logic [2:0] SEL_LSE   = 3'b101;
  localparam logic [2:0] SEL_LSI   = 3'b110;
  localparam logic [2:0] SEL_OFF   = 3'b111;
endpackage

// File: rtl/clkx_sampler.sv
module clkx_sampler #(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] raw,
  output logic [N-1:0] lvl,
  output logic [N-1:0] rise
);
  logic [N-1:0] q_now, q_old;

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) begin
        q_now[i] <= 1'b0;
        q_old[i] <= 1'b0;
      end else begin
        q_now[i] <= raw[i];
        q_old[i] <= q_now[i];
      end
    end
    assign rise[i] = q_now[i] & ~q_old[i];
  end

  assign lvl = q_now;
endmodule

// File: rtl/clkx_divider.sv
module clkx_divider #(
  parameter int CW = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          tick,
  input  logic [CW-1:0] half,
  output logic          wave
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt  <= '0;
      wave <= 1'b0;
    end else if (tick) begin
      if (cnt == half - 1'b1) begin
        cnt  <= '0;
        wave <= ~wave;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R11: the count stays below the half period, so both phases are equal
  a_r11_count_bound: assert property (@(posedge clk) disable iff (rst)
    (!clr && half != '0) |=> (cnt < $past(half)));
endmodule

// File: rtl/clk_export_mux.sv
module clk_export_mux #(
  parameter int PW      = 8,
  parameter int FIX_DIV = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sys_ck,
  input  logic          bus_ck,
  input  logic          hse_ck,
  input  logic          hsi_ck,
  input  logic          lse_ck,
  input  logic          lsi_ck,
  input  logic [2:0]    sel,
  input  logic [PW-1:0] presc,
  output logic          ck_out
);
  import clkx_pkg::*;

  localparam int CW = PW + 1;
  localparam logic [CW-1:0] FIX_HALF = CW'(FIX_DIV / 2);

  logic [NSRC-1:0] lvl, rise;
  logic [2:0]      cur_sel;
  logic [PW-1:0]   cur_pre;
  logic            pend, swap, tick, wave;
  logic [CW-1:0]   half;
  logic            nxt_out;

  clkx_sampler #(.N(NSRC)) u_samp (
    .clk  (clk),
    .rst  (rst),
    .raw  ({lsi_ck, lse_ck, hsi_ck, hse_ck, bus_ck, sys_ck}),
    .lvl  (lvl),
    .rise (rise)
  );

  assign pend = (sel != cur_sel) || (presc != cur_pre);
  assign swap = pend && !ck_out;

  always_comb begin
    tick = 1'b0;
    case (cur_sel)
      SEL_REF, SEL_SYS16: tick = rise[IX_SYS];
      SEL_BUS16:          tick = rise[IX_BUS];
      SEL_HSE16:          tick = rise[IX_HSE];
      SEL_HSI16:          tick = rise[IX_HSI];
      default:            tick = 1'b0;
    endcase
  end

  assign half = (cur_sel == SEL_REF) ? ({1'b0, cur_pre} + 1'b1) : FIX_HALF;

  clkx_divider #(.CW(CW)) u_div (
    .clk  (clk),
    .rst  (rst),
    .clr  (swap),
    .tick (tick),
    .half (half),
    .wave (wave)
  );

  always_comb begin
    case (cur_sel)
      SEL_LSE: nxt_out = lvl[IX_LSE];
      SEL_LSI: nxt_out = lvl[IX_LSI];
      SEL_OFF: nxt_out = 1'b0;
      default: nxt_out = wave;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_sel <= SEL_OFF;
      cur_pre <= '0;
      ck_out  <= 1'b0;
    end else if (swap) begin
      cur_sel <= sel;
      cur_pre <= presc;
      ck_out  <= 1'b0;
    end else begin
      ck_out <= nxt_out;
    end
  end

  // R9: the active code only moves across a low output
  a_r9_switch_low: assert property (@(posedge clk) disable iff (rst)
    (cur_sel != $past(cur_sel)) |-> (!$past(ck_out) && !ck_out));

  // R8: unused code keeps the pin low
  a_r8_off_low: assert property (@(posedge clk) disable iff (rst)
    (cur_sel == SEL_OFF) |-> !ck_out);

  // R7: passthrough tracks the sampled low-speed level
  a_r7_pass_lse: assert property (@(posedge clk) disable iff (rst)
    (cur_sel == SEL_LSE && $past(cur_sel) == SEL_LSE) |-> (ck_out == $past(lvl[IX_LSE])));
endmodule

// File: tb/clk_export_mux_tb.sv
module clk_export_mux_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [5:0] src = '0;
  logic [2:0] sel_r = 3'b000;
  logic [7:0] pre_r = 8'd0;
  logic ck_out;

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit done = 0;

  always #5 clk = ~clk;

  clk_export_mux u_dut (
    .clk(clk), .rst(rst),
    .sys_ck(src[0]), .bus_ck(src[1]), .hse_ck(src[2]),
    .hsi_ck(src[3]), .lse_ck(src[4]), .lsi_ck(src[5]),
    .sel(sel_r), .presc(pre_r), .ck_out(ck_out)
  );

  // source waveforms: half periods in base cycles
  int hp [6] = '{1, 2, 3, 2, 20, 27};
  int sc [6] = '{0, 0, 0, 0, 0, 0};
  always @(negedge clk) begin
    for (int i = 0; i < 6; i++) begin
      sc[i] = sc[i] + 1;
      if (sc[i] >= hp[i]) begin sc[i] = 0; src[i] <= ~src[i]; end
    end
  end

  // behavioural reference
  logic [5:0] m_sq = '0, m_sd = '0, m_r;
  int m_sel = 7, m_pre = 0, m_cnt = 0, m_half;
  bit m_wave = 0, m_out = 0, m_tk, m_nout;
  string m_tag = "R1";

  function automatic string tag_of(int s);
    case (s)
      0: return "R2"; 1: return "R3"; 2: return "R4"; 3: return "R5";
      4: return "R6"; 5, 6: return "R7"; default: return "R8";
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_sq = '0; m_sd = '0; m_sel = 7; m_pre = 0; m_cnt = 0; m_wave = 0; m_out = 0; m_tag = "R1";
    end else begin
      m_r = m_sq & ~m_sd;
      if ((int'(sel_r) != m_sel || int'(pre_r) != m_pre) && !m_out) begin
        m_tag = (int'(sel_r) != m_sel) ? "R9" : "R10";
        m_sel = sel_r; m_pre = pre_r; m_cnt = 0; m_wave = 0; m_out = 0;
      end else begin
        case (m_sel)
          5: m_nout = m_sq[4];
          6: m_nout = m_sq[5];
          7: m_nout = 0;
          default: m_nout = m_wave;
        endcase
        case (m_sel)
          0, 2: m_tk = m_r[0];
          1: m_tk = m_r[1];
          3: m_tk = m_r[2];
          4: m_tk = m_r[3];
          default: m_tk = 0;
        endcase
        m_half = (m_sel == 0) ? m_pre + 1 : 8;
        if (m_tk) begin
          if (m_cnt == m_half - 1) begin m_cnt = 0; m_wave = !m_wave; end
          else m_cnt = m_cnt + 1;
        end
        m_out = m_nout;
        m_tag = tag_of(m_sel);
      end
      m_sd = m_sq; m_sq = src;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      cyc++;
      n_chk++;
      if (ck_out !== m_out) begin
        n_bad++;
        $display("FAIL %s cycle %0d: ck_out=%0b expected %0b", m_tag, cyc, ck_out, m_out);
      end
      if (cyc > 150000) begin
        n_bad++; n_chk++;
        $display("FAIL watchdog: cycles=%0d expected below 150000", cyc);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
      end
    end
  end

  task automatic cfg(input logic [2:0] s, input logic [7:0] p, input int n);
    @(negedge clk);
    sel_r <= s; pre_r <= p;
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  initial begin
    int hi, lo;
    repeat (5) @(negedge clk);
    chk("R1", ck_out, 0);
    rst <= 1'b0;
    @(negedge clk);
    chk("R1", ck_out, 0);
    for (int s = 0; s < 8; s++) cfg(3'(s), 8'd3, 500);
    cfg(3'b000, 8'd0, 300);
    cfg(3'b000, 8'd5, 300);
    cfg(3'b000, 8'd6, 13);    // R10: prescale change mid-phase
    cfg(3'b000, 8'd255, 2300);
    cfg(3'b101, 8'd255, 7);   // R9: select change during high phase
    cfg(3'b011, 8'd255, 11);
    cfg(3'b001, 8'd2, 5);
    cfg(3'b110, 8'd2, 400);
    cfg(3'b100, 8'd2, 300);
    cfg(3'b111, 8'd9, 100);
    cfg(3'b010, 8'd9, 100);
    // R11: system clock /16 has 16 base cycles high and 16 low
    while (ck_out !== 1'b1) @(negedge clk);
    hi = 0; while (ck_out === 1'b1) begin hi++; @(negedge clk); end
    lo = 0; while (ck_out === 1'b0) begin lo++; @(negedge clk); end
    chk("R11 high", hi, 16);
    chk("R11 low", lo, 16);
    cfg(3'b000, 8'd4, 20);
    while (ck_out !== 1'b1) @(negedge clk);
    hi = 0; while (ck_out === 1'b1) begin hi++; @(negedge clk); end
    lo = 0; while (ck_out === 1'b0) begin lo++; @(negedge clk); end
    chk("R2 high", hi, 10);
    chk("R2 low", lo, 10);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule